// File: doc/BRIEF.md
# Integer Execution Unit with Set-on-Compare

This block is the integer datapath of a 32-bit load/store processor. It takes a first source operand, a second source operand that is either a register value or a 16-bit immediate, and an operation code, and it produces one result word. The operations are add, subtract, bitwise AND/OR/XOR, three shifts, six signed comparisons that each produce a 0 or 1 word, and a load-high operation. The load-high operation places the immediate at the top of the word and clears the bits below it.

The arithmetic is purely combinational. A parameter can place a register at the output, which then holds its value while no new operation is issued. The destination register index travels alongside the result. A small gate drops any write aimed at register index 0, because that register always reads as zero. For this reason a load-immediate is issued as an add of the immediate to register 0, and a register move is issued as an add of the source to register 0.

Top module: `int_exec_unit`

## Requirements
- R1: Op 0 (add) and op 1 (subtract) return src_a plus or minus the second operand, wrapped modulo 2^DATA_W, with no error indication.
- R2: Op 2 (AND), op 3 (OR) and op 4 (XOR) are bitwise. When use_imm is 1, these ops zero-extend the immediate.
- R3: Op 5 (shift left), op 6 (logical shift right) and op 7 (arithmetic shift right) take the shift amount from the low log2(DATA_W) bits of the second operand. Shift left and logical shift right fill with zeros. Arithmetic shift right fills with the sign bit.
- R4: Ops 8 to 13 compare as signed two's-complement numbers: op 8 less-than, op 9 greater-than, op 10 less-or-equal, op 11 greater-or-equal, op 12 equal, op 13 not-equal. The result is 1 when the condition holds and 0 otherwise, zero-extended to DATA_W.
- R5: When use_imm is 1, every op other than 2, 3 and 4 sign-extends the IMM_W-bit immediate to form the second operand.
- R6: Op 14 (load-high) returns imm in the top IMM_W bits with all lower bits zero. It ignores src_a, src_b and use_imm.
- R7: Op 15 is reserved and returns zero.
- R8: wr_en is 1 only when a result is valid and its destination index is nonzero. wr_idx carries the destination index of that result.
- R9: With OUT_REG=1, an operation issued with in_valid=1 appears on result, out_valid and wr_idx one clock later. While in_valid is 0, result keeps its previous value and out_valid is 0. With OUT_REG=0, the outputs follow the inputs in the same cycle.
- R10: While rst_n is low, out_valid and wr_en are 0 and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is issued this cycle |
| op | input | 4 | Operation code (see R1 to R7) |
| use_imm | input | 1 | Second operand comes from imm instead of src_b |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand (register form) |
| imm | input | IMM_W | Immediate field |
| dest_idx | input | IDX_W | Destination register index |
| out_valid | output | 1 | result holds a new value |
| result | output | DATA_W | Operation result |
| wr_en | output | 1 | Register-file write enable, never set for index 0 |
| wr_idx | output | IDX_W | Register-file write index |

## Verification
The main instance is built with DATA_W=8, IMM_W=4 and OUT_REG=1. At that width every opcode can be swept against all 256 first-operand values, once against every immediate and once against a set of second-operand register values. Those values include zero, all-ones, the most negative value and equality with the first operand. Shift amounts, signed-compare boundaries and sign-extension edges are therefore all reached. A second instance at the default 32-bit width with OUT_REG=0 checks the combinational path, carry wrap, 16-bit immediate sign extension and load-high at full width.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6,
    OP_SRA = 4'd7,
    OP_SLT = 4'd8,
    OP_SGT = 4'd9,
    OP_SLE = 4'd10,
    OP_SGE = 4'd11,
    OP_SEQ = 4'd12,
    OP_SNE = 4'd13,
    OP_LHI = 4'd14,
    OP_RSV = 4'd15
  } exec_op_e;

  function automatic logic is_logic_op(exec_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
  endfunction

  function automatic logic is_cmp_op(exec_op_e o);
    return (o >= OP_SLT) && (o <= OP_SNE);
  endfunction

endpackage

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  exec_op_e            op,
  input  logic                use_imm,
  input  logic [DATA_W-1:0]   reg_b,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;

  always_comb begin
    imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    imm_zext = {{EXT_W{1'b0}}, imm};
    if (!use_imm)               opnd_b = reg_b;
    else if (is_logic_op(op))   opnd_b = imm_zext;
    else                        opnd_b = imm_sext;
  end
endmodule

// File: rtl/exec_alu_core.sv
module exec_alu_core
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  exec_op_e            op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   res
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - IMM_W;

  logic [SH_W-1:0] sh;
  logic            lt;
  logic            eq;
  logic            flag;

  always_comb begin
    sh   = b[SH_W-1:0];
    lt   = $signed(a) < $signed(b);
    eq   = (a == b);
    flag = 1'b0;
    res  = '0;
    case (op)
      OP_ADD: res = a + b;
      OP_SUB: res = a - b;
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SLL: res = a << sh;
      OP_SRL: res = a >> sh;
      OP_SRA: res = $signed(a) >>> sh;
      OP_SLT: flag = lt;
      OP_SGT: flag = !lt && !eq;
      OP_SLE: flag = lt || eq;
      OP_SGE: flag = !lt;
      OP_SEQ: flag = eq;
      OP_SNE: flag = !eq;
      OP_LHI: res = {imm, {LOW_W{1'b0}}};
      default: res = '0;
    endcase
    if (is_cmp_op(op)) res = {{(DATA_W-1){1'b0}}, flag};
  end
endmodule

// File: rtl/exec_dest_gate.sv
module exec_dest_gate #(
  parameter int IDX_W = 5
) (
  input  logic             res_valid,
  input  logic [IDX_W-1:0] res_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  always_comb begin
    wr_idx = res_idx;
    wr_en  = res_valid && (res_idx != '0);
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int IDX_W   = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);
  localparam int LOW_W = DATA_W - IMM_W;

  exec_op_e          op_e;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] core_res;
  logic              stg_valid;
  logic [IDX_W-1:0]  stg_idx;

  assign op_e = exec_op_e'(op);

  exec_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op(op_e), .use_imm(use_imm), .reg_b(src_b), .imm(imm), .opnd_b(opnd_b)
  );

  exec_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op(op_e), .a(src_a), .b(opnd_b), .imm(imm), .res(core_res)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_d, res_q;
      logic              vld_d, vld_q;
      logic [IDX_W-1:0]  idx_d, idx_q;

      always_comb begin
        vld_d = in_valid;
        res_d = in_valid ? core_res : res_q;
        idx_d = in_valid ? dest_idx : idx_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          idx_q <= '0;
        end else begin
          vld_q <= vld_d;
          res_q <= res_d;
          idx_q <= idx_d;
        end
      end

      assign result    = res_q;
      assign stg_valid = vld_q;
      assign stg_idx   = idx_q;

      AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && result == $past(core_res))); // R9
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R9
    end else begin : g_comb
      assign result    = core_res;
      assign stg_valid = in_valid;
      assign stg_idx   = dest_idx;
    end
  endgenerate

  assign out_valid = stg_valid;

  exec_dest_gate #(.IDX_W(IDX_W)) u_gate (
    .res_valid(stg_valid), .res_idx(stg_idx), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == '0) |-> !wr_en); // R8
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid); // R8
  AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp_op(op_e) |-> (core_res[DATA_W-1:1] == '0)); // R4
  AST_LHI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_LHI) |-> (core_res[LOW_W-1:0] == '0 && core_res[DATA_W-1:LOW_W] == imm)); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RSV) |-> (core_res == '0)); // R7
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;

  // small configuration, registered output
  logic       iv, ui, ov, we;
  logic [3:0] opc, im;
  logic [7:0] sa, sb, res;
  logic [4:0] di, wi;

  int_exec_unit #(.DATA_W(8), .IMM_W(4), .IDX_W(5), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .op(opc), .use_imm(ui),
    .src_a(sa), .src_b(sb), .imm(im), .dest_idx(di),
    .out_valid(ov), .result(res), .wr_en(we), .wr_idx(wi)
  );

  // full width, combinational output
  logic        iv1, ui1, ov1, we1;
  logic [3:0]  opc1;
  logic [15:0] im1;
  logic [31:0] sa1, sb1, res1;
  logic [4:0]  di1, wi1;

  int_exec_unit #(.OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .op(opc1), .use_imm(ui1),
    .src_a(sa1), .src_b(sb1), .imm(im1), .dest_idx(di1),
    .out_valid(ov1), .result(res1), .wr_en(we1), .wr_idx(wi1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref8(input int o, input logic u, input logic [7:0] ra,
                                      input logic [7:0] rb, input logic [3:0] ii);
    logic [7:0] b;
    logic [7:0] r;
    int xa, xb, sh;
    if (u) b = (o >= 2 && o <= 4) ? {4'h0, ii} : {{4{ii[3]}}, ii};
    else   b = rb;
    xa = (int'(ra) >= 128) ? int'(ra) - 256 : int'(ra);
    xb = (int'(b)  >= 128) ? int'(b)  - 256 : int'(b);
    sh = int'(b) % 8;
    r = 8'h00;
    case (o)
      0:  r = 8'((int'(ra) + int'(b)) % 256);
      1:  r = 8'((int'(ra) - int'(b) + 256) % 256);
      2:  r = ra & b;
      3:  r = ra | b;
      4:  r = ra ^ b;
      5:  r = 8'((int'(ra) * (1 << sh)) % 256);
      6:  r = 8'(int'(ra) / (1 << sh));
      7:  begin r = ra; for (int i = 0; i < sh; i++) r = {r[7], r[7:1]}; end
      8:  r = (xa <  xb) ? 8'd1 : 8'd0;
      9:  r = (xa >  xb) ? 8'd1 : 8'd0;
      10: r = (xa <= xb) ? 8'd1 : 8'd0;
      11: r = (xa >= xb) ? 8'd1 : 8'd0;
      12: r = (xa == xb) ? 8'd1 : 8'd0;
      13: r = (xa != xb) ? 8'd1 : 8'd0;
      14: r = {ii, 4'h0};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int o, input logic u);
    if (o == 15) return "R7";
    if (o == 14) return "R6";
    if (u && !(o >= 2 && o <= 4)) return "R5";
    if (o <= 1) return "R1";
    if (o <= 4) return "R2";
    if (o <= 7) return "R3";
    return "R4";
  endfunction

  logic       have = 1'b0;
  logic [7:0] e_res = 8'h00;
  logic       e_vld, e_we;
  logic [4:0] e_idx;
  string      e_tag;

  task automatic step(input logic v, input int o, input logic u, input logic [7:0] a,
                      input logic [7:0] b, input logic [3:0] ii, input logic [4:0] d);
    @(negedge clk);
    if (have) begin
      chk(e_tag, {24'h0, res}, {24'h0, e_res});
      chk("R8/R9 valid+write", {ov, we, wi}, {e_vld, e_we, e_we ? e_idx : wi});
    end
    iv = v; opc = 4'(o); ui = u; sa = a; sb = b; im = ii; di = d;
    if (v) begin
      e_res = ref8(o, u, a, b, ii);
      e_vld = 1'b1; e_we = (d != 5'd0); e_idx = d;
      e_tag = tag_of(o, u);
    end else begin
      e_vld = 1'b0; e_we = 1'b0; e_tag = "R9 hold";
    end
    have = 1'b1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iv = 0; opc = 0; ui = 0; sa = 0; sb = 0; im = 0; di = 0;
    iv1 = 0; opc1 = 0; ui1 = 0; sa1 = 0; sb1 = 0; im1 = 0; di1 = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset", {ov, we, res}, {1'b0, 1'b0, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);

    // register form: all ops, all first operands, chosen second operands
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 18; k++) begin
          logic [7:0] b;
          b = (k < 16) ? 8'(k * 17) : (k == 16 ? 8'h80 : 8'(a));
          step(1'b1, o, 1'b0, 8'(a), b, 4'(k), 5'(a + k));
        end
    // immediate form: every immediate (R5 sign extension, R2 zero extension)
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 16; m++)
          step(1'b1, o, 1'b1, 8'(a), 8'(255 - a), 4'(m), 5'(m * 3 + a));
    // idle cycles: R9 hold with changing operands
    step(1'b1, 0, 1'b0, 8'h12, 8'h34, 4'h0, 5'd0);
    for (int t = 0; t < 4; t++) step(1'b0, t, 1'b0, 8'(t * 40), 8'(t + 9), 4'(t), 5'(t + 1));
    step(1'b0, 0, 1'b0, 8'h00, 8'h00, 4'h0, 5'd0);

    // full width, combinational (R9 OUT_REG=0)
    @(negedge clk);
    iv1 = 1; di1 = 5'd7; opc1 = 4'd0; ui1 = 0; sa1 = 32'hFFFF_FFFF; sb1 = 32'h1;
    #1 chk("R1 wrap 32", res1, 32'h0);
    chk("R9 comb valid", {ov1, we1, wi1}, {1'b1, 1'b1, 5'd7});
    opc1 = 4'd0; ui1 = 1; sa1 = 32'h0; im1 = 16'h8000; di1 = 5'd0;
    #1 chk("R5 sext 16", res1, 32'hFFFF_8000);
    chk("R8 idx0 no write", {31'h0, we1}, 32'h0);
    opc1 = 4'd2; ui1 = 1; sa1 = 32'hFFFF_FFFF; im1 = 16'h8001;
    #1 chk("R2 zext 16", res1, 32'h0000_8001);
    opc1 = 4'd14; ui1 = 0; sa1 = 32'h1234_5678; sb1 = 32'h9ABC_DEF0; im1 = 16'hABCD;
    #1 chk("R6 lhi 32", res1, 32'hABCD_0000);
    opc1 = 4'd8; sa1 = 32'hFFFF_FFFF; sb1 = 32'h1;
    #1 chk("R4 slt 32", res1, 32'h1);
    opc1 = 4'd7; sa1 = 32'h8000_0000; sb1 = 32'h3F;
    #1 chk("R3 sra 32", res1, 32'hFFFF_FFFF);
    iv1 = 0; opc1 = 4'd0; sa1 = 32'h5; sb1 = 32'h5; di1 = 5'd3;
    #1 chk("R9 comb idle", {30'h0, ov1, we1}, 32'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule